// File: doc/BRIEF.md
# Multi-Cycle Per-Flow Counter Pipeline

This block performs a read-modify-write update on a per-flow state table, and the update takes several clock cycles. Each accepted header carries a full flow key and a short flow tag. The first stage reads the counter that the key selects. The middle stages carry the value forward. The last stage holds the incremented value, and that value is written back into the table on the following edge.

Because the read and the write-back are separated in time, two headers of the same flow can overlap in the pipeline. The later one would then read a stale counter. The block does not stall or reorder anything to prevent this. Instead it publishes the valid bit and tag of every stage, so that an upstream admission scheduler can hold back a same-flow header. It also keeps a sticky flag that records any admission that collided with a flow still in flight.

A same-flow header that enters exactly when its predecessor reaches the last stage is safe: the value being written back is forwarded to the read. A single flow can therefore be admitted once every `NUM_STAGES` cycles, and with one stage no collision is possible. Headers of different flows may enter back to back.

Top module: `flow_rmw_pipe`

## Requirements
- R1: After reset, every stage valid bit is 0, `hazardFlag` is 0, `doneValid` is 0, and every counter in the table is 0, so the first header of any flow completes with value 1.
- R2: A header is accepted on every edge where `inValid` is 1. It appears in stage s (bit s-1 of `stageValid`, tag at bits `[(s-1)*TAG_W +: TAG_W]` of `stageTag`) s edges after acceptance.
- R3: `NUM_STAGES` edges after acceptance, `doneValid` is 1, `doneKey` equals the header's key, and `doneValue` equals the counter value that was read, plus one.
- R4: The increment saturates: a counter that holds all ones (`2**DATA_W-1`) stays at all ones.
- R5: The table has `2**IDX_W` entries indexed by the low `IDX_W` bits of the key. Keys that differ only above those bits share one counter.
- R6: The result held in the last stage is written to the table on the next edge. A same-flow header accepted on that same edge reads the written value, so headers spaced exactly `NUM_STAGES` cycles apart count consecutively.
- R7: Headers of different table entries accepted on consecutive cycles update their own counters independently.
- R8: `hazardFlag` becomes 1 on the edge after an accepted header whose tag equals the tag of a valid header in stages 1 to `NUM_STAGES-1`. A match with the last stage, or with an invalid stage, does not set it.
- R9: `hazardFlag` stays 1 until an edge where `hazClear` is 1 and no new collision is detected. A collision detected on the same edge as `hazClear` leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A header is offered and accepted this cycle |
| inKey | input | KEY_W | Full flow key of the offered header |
| inTag | input | TAG_W | Short flow tag of the offered header |
| hazClear | input | 1 | Synchronous clear of the sticky collision flag |
| stageValid | output | NUM_STAGES | Valid bit of each stage, bit 0 is stage 1 |
| stageTag | output | NUM_STAGES*TAG_W | Tag of each stage, stage 1 in the low bits |
| hazardFlag | output | 1 | Sticky same-tag collision indicator |
| doneValid | output | 1 | Last stage holds a header whose result is written on the next edge |
| doneKey | output | KEY_W | Key of the header in the last stage |
| doneValue | output | DATA_W | Updated counter value being written back |

## Verification
The assertions assume that `inValid`, `inKey`, `inTag` and `hazClear` are stable across each rising edge. They also assume that reset is held for at least one edge before any header is offered. The bench changes inputs only on falling edges and releases reset before the first header. The assertions also assume that the upstream logic derives the tag from the key. The stimulus, however, deliberately sends colliding and aliasing headers. A reference table in the bench reproduces the stale reads they cause, so the expected counter values stay exact even when the scheduler rules are broken.

// File: rtl/flow_rmw_pkg.sv
package flow_rmw_pkg;
  typedef struct packed {
    logic load;   // capture a new header into stage 1
    logic wrEn;   // last stage is valid: write its result back
  } rmw_strobe_t;
endpackage

// File: rtl/flow_rmw_ctrl.sv
module flow_rmw_ctrl
  import flow_rmw_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int TAG_W      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [TAG_W-1:0]            inTag,
  input  logic                        hazClear,
  output rmw_strobe_t                 strobe,
  output logic [NUM_STAGES-1:0]       stageValid,
  output logic [NUM_STAGES*TAG_W-1:0] stageTag,
  output logic                        hazardFlag
);
  logic [NUM_STAGES-1:0] vldQ;
  logic [TAG_W-1:0]      tagQ [NUM_STAGES];
  logic                  hazHit;
  logic                  hazSet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vldQ <= '0;
      for (int s = 0; s < NUM_STAGES; s++) tagQ[s] <= '0;
    end else begin
      vldQ[0] <= inValid;
      if (inValid) tagQ[0] <= inTag;
      for (int s = 1; s < NUM_STAGES; s++) begin
        vldQ[s] <= vldQ[s-1];
        tagQ[s] <= tagQ[s-1];
      end
    end
  end

  // Only stages whose write-back lies after this read can collide;
  // the last stage's result is forwarded to the read.
  generate
    if (NUM_STAGES > 1) begin : g_hit
      logic [NUM_STAGES-2:0] matchVec;
      for (genvar s = 0; s < NUM_STAGES-1; s++) begin : g_cmp
        assign matchVec[s] = vldQ[s] && (tagQ[s] == inTag);
      end
      assign hazHit = |matchVec;
    end else begin : g_nohit
      assign hazHit = 1'b0;
    end
  endgenerate

  assign hazSet = inValid && hazHit;

  always_ff @(posedge clk) begin
    if (!rst_n)        hazardFlag <= 1'b0;
    else if (hazSet)   hazardFlag <= 1'b1;
    else if (hazClear) hazardFlag <= 1'b0;
  end

  assign strobe.load = inValid;
  assign strobe.wrEn = vldQ[NUM_STAGES-1];
  assign stageValid  = vldQ;

  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_tagOut
      assign stageTag[s*TAG_W +: TAG_W] = tagQ[s];
    end
    for (genvar s = 1; s < NUM_STAGES; s++) begin : g_advChk
      AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        stageValid[s-1] |=> stageValid[s]);  // R2
    end
  endgenerate

  AST_ENTRY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> stageValid[0]);  // R2
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !stageValid[0]);  // R2
  AST_HAZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (hazardFlag && !hazClear) |=> hazardFlag);  // R9
  AST_HAZ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (hazClear && !inValid) |=> !hazardFlag);  // R9
endmodule

// File: rtl/flow_rmw_dp.sv
module flow_rmw_dp
  import flow_rmw_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int KEY_W      = 16,
  parameter int IDX_W      = 4,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rmw_strobe_t       strobe,
  input  logic [KEY_W-1:0]  inKey,
  output logic [KEY_W-1:0]  doneKey,
  output logic [DATA_W-1:0] doneValue
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LAST  = NUM_STAGES - 1;

  logic [DATA_W-1:0] stateMem [DEPTH];
  logic [KEY_W-1:0]  keyQ [NUM_STAGES];
  logic [DATA_W-1:0] valQ [NUM_STAGES];
  logic [IDX_W-1:0]  rdIdx;
  logic [IDX_W-1:0]  wbIdx;
  logic [DATA_W-1:0] rdVal;

  function automatic logic [DATA_W-1:0] satInc(input logic [DATA_W-1:0] v);
    return (&v) ? v : v + DATA_W'(1);
  endfunction

  assign rdIdx = inKey[IDX_W-1:0];
  assign wbIdx = keyQ[LAST][IDX_W-1:0];
  // forward the value being written this edge to a same-entry read
  assign rdVal = (strobe.wrEn && (wbIdx == rdIdx)) ? valQ[LAST] : stateMem[rdIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stateMem[i] <= '0;
    end else if (strobe.wrEn) begin
      stateMem[wbIdx] <= valQ[LAST];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_STAGES; s++) keyQ[s] <= '0;
    end else begin
      if (strobe.load) keyQ[0] <= inKey;
      for (int s = 1; s < NUM_STAGES; s++) keyQ[s] <= keyQ[s-1];
    end
  end

  generate
    if (NUM_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)           valQ[0] <= '0;
        else if (strobe.load) valQ[0] <= satInc(rdVal);
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int s = 0; s < NUM_STAGES; s++) valQ[s] <= '0;
        end else begin
          if (strobe.load) valQ[0] <= rdVal;
          for (int s = 1; s < LAST; s++) valQ[s] <= valQ[s-1];
          valQ[LAST] <= satInc(valQ[LAST-1]);
        end
      end
    end
  endgenerate

  assign doneKey   = keyQ[LAST];
  assign doneValue = valQ[LAST];

  AST_WB_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> (stateMem[$past(wbIdx)] == $past(valQ[LAST])));  // R6
  AST_RESULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |-> (doneValue != '0));  // R4
endmodule

// File: rtl/flow_rmw_pipe.sv
module flow_rmw_pipe
  import flow_rmw_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int KEY_W      = 16,
  parameter int TAG_W      = 4,
  parameter int IDX_W      = 4,
  parameter int DATA_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [KEY_W-1:0]            inKey,
  input  logic [TAG_W-1:0]            inTag,
  input  logic                        hazClear,
  output logic [NUM_STAGES-1:0]       stageValid,
  output logic [NUM_STAGES*TAG_W-1:0] stageTag,
  output logic                        hazardFlag,
  output logic                        doneValid,
  output logic [KEY_W-1:0]            doneKey,
  output logic [DATA_W-1:0]           doneValue
);
  rmw_strobe_t strobe;

  flow_rmw_ctrl #(.NUM_STAGES(NUM_STAGES), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inTag(inTag),
    .hazClear(hazClear), .strobe(strobe), .stageValid(stageValid),
    .stageTag(stageTag), .hazardFlag(hazardFlag)
  );

  flow_rmw_dp #(.NUM_STAGES(NUM_STAGES), .KEY_W(KEY_W), .IDX_W(IDX_W),
                .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inKey(inKey),
    .doneKey(doneKey), .doneValue(doneValue)
  );

  assign doneValid = stageValid[NUM_STAGES-1];

  AST_DONE_KEEPS_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> strobe.wrEn);  // R6
endmodule

// File: tb/flow_rmw_pipe_tb.sv
module flow_rmw_pipe_tb;
  localparam int N  = 4;
  localparam int KW = 8;
  localparam int TW = 4;
  localparam int IW = 3;
  localparam int DW = 3;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [KW-1:0] inKey = '0;
  logic [TW-1:0] inTag = '0;
  logic hazClear = 1'b0;
  logic [N-1:0] stageValid;
  logic [N*TW-1:0] stageTag;
  logic hazardFlag, doneValid;
  logic [KW-1:0] doneKey;
  logic [DW-1:0] doneValue;

  flow_rmw_pipe #(.NUM_STAGES(N), .KEY_W(KW), .TAG_W(TW), .IDX_W(IW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inKey(inKey), .inTag(inTag),
    .hazClear(hazClear), .stageValid(stageValid), .stageTag(stageTag),
    .hazardFlag(hazardFlag), .doneValid(doneValid), .doneKey(doneKey),
    .doneValue(doneValue)
  );

  always #10 clk = ~clk;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state built from the requirements
  int mMem [1<<IW];
  bit mV [N];
  int mK [N];
  int mT [N];
  int mVal [N];
  bit mHaz = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    finished = 1;
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++;
      $display("FAIL watchdog: run hung act=%0d exp<=100000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int satInc(int v);
    return (v == MAXV) ? v : v + 1;
  endfunction

  task automatic step(bit v, int key, int tag, bit clr, string focus);
    bit hit;
    int rd;
    longint expTags;
    longint expVld;
    inValid = v; inKey = KW'(key); inTag = TW'(tag); hazClear = clr;
    @(posedge clk);
    hit = 0;
    for (int s = 0; s < N-1; s++) if (mV[s] && mT[s] == tag) hit = 1;
    if (v && hit) mHaz = 1; else if (clr) mHaz = 0;
    if (mV[N-1]) mMem[mK[N-1] % (1<<IW)] = mVal[N-1];
    rd = mMem[key % (1<<IW)];
    for (int s = N-1; s >= 1; s--) begin
      mV[s] = mV[s-1]; mK[s] = mK[s-1]; mT[s] = mT[s-1];
      mVal[s] = (s == N-1) ? satInc(mVal[s-1]) : mVal[s-1];
    end
    mV[0] = v;
    if (v) begin mK[0] = key; mT[0] = tag; mVal[0] = rd; end
    @(negedge clk);
    inValid = 0; hazClear = 0;
    expTags = 0; expVld = 0;
    for (int s = 0; s < N; s++) begin
      expVld |= longint'(mV[s]) << s;
      expTags |= longint'(mT[s]) << (s*TW);
    end
    chk("R2 stageValid", stageValid, expVld);
    chk("R2 stageTag", stageTag, expTags);
    chk("R3 doneValid", doneValid, mV[N-1]);
    if (mV[N-1]) begin
      chk("R3 doneKey", doneKey, mK[N-1]);
      chk({focus, " doneValue"}, doneValue, mVal[N-1]);
    end
    chk({focus, " hazardFlag"}, hazardFlag, mHaz);
  endtask

  task automatic idle(int n, string focus);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, focus);
  endtask

  initial begin
    int lfsr;
    for (int i = 0; i < (1<<IW); i++) mMem[i] = 0;
    for (int s = 0; s < N; s++) begin mV[s] = 0; mK[s] = 0; mT[s] = 0; mVal[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 stageValid", stageValid, 0);
    chk("R1 hazardFlag", hazardFlag, 0);
    chk("R1 doneValid", doneValid, 0);

    // R1/R4/R6: one flow spaced exactly N cycles, first result 1, saturates at MAXV
    step(1, 5, 5, 0, "R1"); idle(N-1, "R1");
    for (int i = 0; i < 9; i++) begin
      step(1, 5, 5, 0, (i < 5) ? "R6" : "R4");
      idle(N-1, (i < 5) ? "R6" : "R4");
    end
    idle(N, "R4");

    // R7: distinct entries back to back
    for (int k = 0; k < 8; k++) step(1, k, k + 8, 0, "R7");
    for (int k = 0; k < 8; k++) step(1, k, k + 8, 0, "R7");
    idle(N, "R7");

    // R5: keys aliasing on the low index bits share a counter
    step(1, 8'h23, 1, 0, "R5"); idle(N-1, "R5");
    step(1, 8'h03, 2, 0, "R5"); idle(N-1, "R5");
    step(1, 8'h63, 3, 0, "R5"); idle(N, "R5");

    // R8: same tag re-entered after every gap from 1 to N
    for (int g = 1; g <= N; g++) begin
      step(1, 8'h40 + g, 9, 0, "R8");
      idle(g - 1, "R8");
      step(1, 8'h40 + g, 9, 0, "R8");
      idle(N, "R8");
      step(0, 0, 0, 1, "R8");
    end
    // R8: matching tag only in the last stage does not set the flag
    step(1, 1, 7, 0, "R8"); idle(N-1, "R8"); step(1, 2, 7, 0, "R8"); idle(N, "R8");

    // R9: sticky, and set wins over a simultaneous clear
    step(1, 6, 6, 0, "R9"); step(1, 6, 6, 0, "R9"); idle(1, "R9");
    step(1, 6, 6, 1, "R9"); idle(N, "R9");
    step(0, 0, 0, 1, "R9"); idle(2, "R9");

    // near-exhaustive pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      step(lfsr[0] | lfsr[5], (lfsr >> 3) & 8'hFF, (lfsr >> 9) & 4'hF,
           ((lfsr >> 13) & 7) == 0, "R3");
    end
    idle(N + 1, "R3");
    summary();
  end
endmodule